// File: doc/BRIEF.md
# Modem Control Handshake Sequencer

This block runs the RS-232-style control flow for a point-to-point data link. The user terminal asks for service by holding both its request-to-send and terminal-ready lines low. The sequencer then asks the link controller to start up the link with the remote unit. It keeps clear-to-send negated while the acquisition exchange is in progress. Clear-to-send is asserted only once the link controller reports that acquisition has finished. Carrier-detect follows only after the first burst of real data arrives in that state.

The link controller supplies three indications: acquisition finished, a data burst received, and loss of signal. It also supplies a strobe once per burst period. The sequencer counts these strobes during acquisition. If acquisition takes longer than a programmable number of burst periods, it raises a timeout flag and starts counting again, while still asking for the link. Both user lines pass through a two-stage synchronizer before the state machine sees them. Releasing either line shuts the whole flow down one clock after the synchronized change.

Top module: `modem_handshake_seq`

## Requirements
- R1: After reset, ctsN and dcdN are high, and linkReq, txAccept and acqTimeout are low.
- R2: While the sequencer is idle and rtsN or dtrN (or both) is high, the outputs keep their reset values. In that state acqDone, dataBurstRx, sigLost and burstTick have no effect.
- R3: rtsN and dtrN are low at a rising edge k. From edge k+2 linkReq is high, while ctsN stays high. After edge k+1 linkReq is still low, because of the two synchronizer stages.
- R4: acqDone is high at an edge while the sequencer is acquiring. From that edge ctsN is low, and txAccept is always the inverse of ctsN.
- R5: dcdN goes low only at an edge where dataBurstRx is high and ctsN is already low. Data bursts seen during acquisition are ignored.
- R6: dcdN is never low while ctsN is high, and ctsN is never low while linkReq is low.
- R7: rtsN or dtrN is high at a rising edge k. From edge k+2 ctsN and dcdN are high and linkReq is low, so the sequencer is idle again.
- R8: While acquiring, the acqLimit-th burstTick sets acqTimeout at that edge. The sequencer keeps acquiring and the period count restarts from zero. An acqLimit of 0 disables the timeout.
- R9: sigLost at an edge while dcdN is low sets dcdN high and leaves ctsN low. A later dataBurstRx asserts dcdN again.
- R10: acqTimeout stays set until the sequencer leaves acquisition, and it clears at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtsN | input | 1 | User request-to-send, active low, asynchronous |
| dtrN | input | 1 | User terminal-ready, active low, asynchronous |
| acqDone | input | 1 | Link controller: acquisition exchange finished |
| dataBurstRx | input | 1 | Link controller: burst carrying real data received |
| sigLost | input | 1 | Link controller: received signal lost |
| burstTick | input | 1 | One-cycle strobe per burst period |
| acqLimit | input | CNT_W | Burst periods allowed for acquisition (0 disables) |
| ctsN | output | 1 | Clear-to-send, active low |
| dcdN | output | 1 | Carrier-detect, active low |
| linkReq | output | 1 | Request to the link controller to run the link |
| txAccept | output | 1 | Serial transmit data is accepted |
| acqTimeout | output | 1 | Acquisition exceeded acqLimit burst periods |

## Verification
The assertions assume that the link-controller indications are synchronous single-cycle strobes. They also assume that acqLimit changes only while the sequencer is idle. Only rtsN and dtrN are taken to be asynchronous. The bench drives every input at the falling clock edge. It pulses each status strobe for exactly one cycle, and it sets acqLimit before it pulls the user lines low. The drop-out assertion reads the user lines at one sampled edge only. It therefore holds for any pattern on rtsN and dtrN, including glitches shorter than a cycle.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACQ     = 2'd1,
    ST_READY   = 2'd2,
    ST_CARRIER = 2'd3
  } linkState_t;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;  // hold the burst-period counter at zero
    logic cntEn;   // count burstTick pulses
    logic toSet;   // raise the acquisition timeout flag
    logic toClr;   // drop the acquisition timeout flag
  } ctrlStrobe_t;

endpackage

// File: rtl/mhs_datapath.sv
module mhs_datapath
  import mhs_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtsN,
  input  logic             dtrN,
  input  logic             burstTick,
  input  logic [CNT_W-1:0] acqLimit,
  input  ctrlStrobe_t      strobe,
  output logic             bothOn,
  output logic             timeoutHit,
  output logic             acqTimeout
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rtsSync;
  logic [SYNC_STAGES-1:0] dtrSync;
  logic [CNT_W-1:0]       periodCnt;

  // Chain of flip-flops per user line, reset to the deasserted level
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            rtsSync[0] <= 1'b1;
            dtrSync[0] <= 1'b1;
          end else begin
            rtsSync[0] <= rtsN;
            dtrSync[0] <= dtrN;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            rtsSync[s] <= 1'b1;
            dtrSync[s] <= 1'b1;
          end else begin
            rtsSync[s] <= rtsSync[s-1];
            dtrSync[s] <= dtrSync[s-1];
          end
        end
      end
    end
  endgenerate

  assign bothOn = ~rtsSync[LAST] & ~dtrSync[LAST];

  assign timeoutHit = burstTick && (acqLimit != '0) &&
                      (periodCnt == acqLimit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (strobe.cntClr) begin
      periodCnt <= '0;
    end else if (strobe.cntEn && burstTick) begin
      periodCnt <= timeoutHit ? '0 : periodCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acqTimeout <= 1'b0;
    end else if (strobe.toClr) begin
      acqTimeout <= 1'b0;
    end else if (strobe.toSet) begin
      acqTimeout <= 1'b1;
    end
  end

endmodule

// File: rtl/mhs_control.sv
module mhs_control
  import mhs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bothOn,
  input  logic        acqDone,
  input  logic        dataBurstRx,
  input  logic        sigLost,
  input  logic        timeoutHit,
  output ctrlStrobe_t strobe,
  output logic        ctsN,
  output logic        dcdN,
  output logic        linkReq,
  output logic        txAccept
);

  linkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (bothOn) stateNext = ST_ACQ;
      ST_ACQ:     if (!bothOn) stateNext = ST_IDLE;
                  else if (acqDone) stateNext = ST_READY;
      ST_READY:   if (!bothOn) stateNext = ST_IDLE;
                  else if (dataBurstRx) stateNext = ST_CARRIER;
      ST_CARRIER: if (!bothOn) stateNext = ST_IDLE;
                  else if (sigLost) stateNext = ST_READY;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.cntClr = (state != ST_ACQ);
    strobe.cntEn  = (state == ST_ACQ);
    strobe.toSet  = (state == ST_ACQ) && (stateNext == ST_ACQ) && timeoutHit;
    strobe.toClr  = (stateNext != ST_ACQ);
  end

  assign linkReq  = (state != ST_IDLE);
  assign ctsN     = !((state == ST_READY) || (state == ST_CARRIER));
  assign dcdN     = (state != ST_CARRIER);
  assign txAccept = !ctsN;

endmodule

// File: rtl/modem_handshake_seq.sv
module modem_handshake_seq
  import mhs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtsN,
  input  logic             dtrN,
  input  logic             acqDone,
  input  logic             dataBurstRx,
  input  logic             sigLost,
  input  logic             burstTick,
  input  logic [CNT_W-1:0] acqLimit,
  output logic             ctsN,
  output logic             dcdN,
  output logic             linkReq,
  output logic             txAccept,
  output logic             acqTimeout
);

  ctrlStrobe_t strobe;
  logic        bothOn;
  logic        timeoutHit;

  mhs_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .rtsN       (rtsN),
    .dtrN       (dtrN),
    .burstTick  (burstTick),
    .acqLimit   (acqLimit),
    .strobe     (strobe),
    .bothOn     (bothOn),
    .timeoutHit (timeoutHit),
    .acqTimeout (acqTimeout)
  );

  mhs_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .bothOn      (bothOn),
    .acqDone     (acqDone),
    .dataBurstRx (dataBurstRx),
    .sigLost     (sigLost),
    .timeoutHit  (timeoutHit),
    .strobe      (strobe),
    .ctsN        (ctsN),
    .dcdN        (dcdN),
    .linkReq     (linkReq),
    .txAccept    (txAccept)
  );

endmodule

// File: rtl/mhs_checker.sv
module mhs_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rtsN,
  input logic             dtrN,
  input logic             acqDone,
  input logic             dataBurstRx,
  input logic             sigLost,
  input logic             burstTick,
  input logic [CNT_W-1:0] acqLimit,
  input logic             ctsN,
  input logic             dcdN,
  input logic             linkReq,
  input logic             txAccept,
  input logic             acqTimeout
);

  assert_dcd_needs_cts_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dcdN |-> !ctsN);

  assert_cts_needs_link_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctsN |-> linkReq);

  assert_cts_after_acq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctsN) |-> $past(acqDone));

  assert_dcd_after_burst_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dcdN) |-> ($past(dataBurstRx) && !$past(ctsN)));

  assert_line_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rtsN, 3) || $past(dtrN, 3)) && $past(rstN, 3))
      |-> (ctsN && dcdN && !linkReq));

  assert_siglost_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!dcdN && sigLost) |=> dcdN);

  assert_timeout_acq_R8: assert property (@(posedge clk) disable iff (!rstN)
    acqTimeout |-> (linkReq && ctsN));

endmodule

bind modem_handshake_seq mhs_checker #(.CNT_W(CNT_W)) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .rtsN        (rtsN),
  .dtrN        (dtrN),
  .acqDone     (acqDone),
  .dataBurstRx (dataBurstRx),
  .sigLost     (sigLost),
  .burstTick   (burstTick),
  .acqLimit    (acqLimit),
  .ctsN        (ctsN),
  .dcdN        (dcdN),
  .linkReq     (linkReq),
  .txAccept    (txAccept),
  .acqTimeout  (acqTimeout)
);

// File: tb/test_modem_handshake_seq.sv
`timescale 1ns/1ps
module test_modem_handshake_seq;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rtsN = 1'b1;
  logic             dtrN = 1'b1;
  logic             acqDone = 1'b0;
  logic             dataBurstRx = 1'b0;
  logic             sigLost = 1'b0;
  logic             burstTick = 1'b0;
  logic [CNT_W-1:0] acqLimit = '0;
  logic             ctsN, dcdN, linkReq, txAccept, acqTimeout;

  typedef struct {
    logic  cts;
    logic  dcd;
    logic  link;
    logic  tmo;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  modem_handshake_seq #(.CNT_W(CNT_W)) i_modem_handshake_seq (
    .clk(clk), .rstN(rstN), .rtsN(rtsN), .dtrN(dtrN), .acqDone(acqDone),
    .dataBurstRx(dataBurstRx), .sigLost(sigLost), .burstTick(burstTick),
    .acqLimit(acqLimit), .ctsN(ctsN), .dcdN(dcdN), .linkReq(linkReq),
    .txAccept(txAccept), .acqTimeout(acqTimeout)
  );

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push the expected outputs for the current cycle
  task automatic expectOut(input logic cts, input logic dcd, input logic link,
                           input logic tmo, input string tag);
    expItem_t it;
    it.cts = cts; it.dcd = dcd; it.link = link; it.tmo = tmo; it.tag = tag;
    expQ.push_back(it);
    #0.1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // Monitor side: pop and compare, sampled between edges
  initial begin
    forever begin
      expItem_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      checks++;
      if (ctsN !== it.cts || dcdN !== it.dcd || linkReq !== it.link ||
          acqTimeout !== it.tmo || txAccept !== !it.cts) begin
        fails++;
        $display("FAIL %s: got cts=%b dcd=%b link=%b tmo=%b tx=%b exp cts=%b dcd=%b link=%b tmo=%b tx=%b",
                 it.tag, ctsN, dcdN, linkReq, acqTimeout, txAccept,
                 it.cts, it.dcd, it.link, it.tmo, !it.cts);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running exp done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    stepN(2);
    expectOut(1, 1, 0, 0, "R1 reset");
    rstN = 1'b1;
    stepN(1);
    expectOut(1, 1, 0, 0, "R1 after reset release");

    // R2: only one line asserted, strobes ignored
    rtsN = 1'b0;
    pulse(acqDone); pulse(dataBurstRx); pulse(burstTick);
    stepN(4);
    expectOut(1, 1, 0, 0, "R2 rts only");
    rtsN = 1'b1; dtrN = 1'b0;
    pulse(sigLost); pulse(acqDone);
    stepN(4);
    expectOut(1, 1, 0, 0, "R2 dtr only");
    dtrN = 1'b1;
    stepN(3);

    // R3: both lines asserted, two sync stages
    acqLimit = 8'd0;
    rtsN = 1'b0; dtrN = 1'b0;
    stepN(2);
    expectOut(1, 1, 0, 0, "R3 sync latency");
    stepN(1);
    expectOut(1, 1, 1, 0, "R3 link request");

    // R5: data burst during acquisition ignored; R8: limit 0 disables
    pulse(dataBurstRx);
    expectOut(1, 1, 1, 0, "R5 burst in acquisition");
    for (int i = 0; i < 10; i++) pulse(burstTick);
    expectOut(1, 1, 1, 0, "R8 limit zero disables");

    // R4: acquisition done
    pulse(acqDone);
    expectOut(0, 1, 1, 0, "R4 cts asserted");
    stepN(3);
    expectOut(0, 1, 1, 0, "R5 no dcd without burst");
    pulse(dataBurstRx);
    expectOut(0, 0, 1, 0, "R5 dcd asserted");

    // R9: signal loss
    pulse(sigLost);
    expectOut(0, 1, 1, 0, "R9 dcd negated, cts kept");
    pulse(dataBurstRx);
    expectOut(0, 0, 1, 0, "R9 dcd reasserted");

    // R7: drop rts from carrier
    rtsN = 1'b1;
    stepN(2);
    expectOut(0, 0, 1, 0, "R7 before sync");
    stepN(1);
    expectOut(1, 1, 0, 0, "R7 rts drop");

    // R8/R10: timeout with limit 3
    acqLimit = 8'd3;
    rtsN = 1'b0;
    stepN(3);
    expectOut(1, 1, 1, 0, "R8 acquiring");
    pulse(burstTick); pulse(burstTick);
    expectOut(1, 1, 1, 0, "R8 below limit");
    pulse(burstTick);
    expectOut(1, 1, 1, 1, "R8 timeout set");
    for (int i = 0; i < 4; i++) pulse(burstTick);
    expectOut(1, 1, 1, 1, "R10 flag sticky");
    pulse(acqDone);
    expectOut(0, 1, 1, 0, "R10 flag cleared on leaving");
    pulse(dataBurstRx);
    expectOut(0, 0, 1, 0, "R5 dcd second session");

    // R7: drop dtr from carrier
    dtrN = 1'b1;
    stepN(3);
    expectOut(1, 1, 0, 0, "R7 dtr drop");

    // R8 restart: timeout, then two ticks, acquisition, drop while acquiring
    dtrN = 1'b0;
    stepN(3);
    for (int i = 0; i < 3; i++) pulse(burstTick);
    expectOut(1, 1, 1, 1, "R8 timeout again");
    rtsN = 1'b1;
    stepN(3);
    expectOut(1, 1, 0, 0, "R10 cleared on drop");
    // counter restarts: re-enter, two ticks must not time out
    rtsN = 1'b0;
    stepN(3);
    pulse(burstTick); pulse(burstTick);
    expectOut(1, 1, 1, 0, "R8 count restarted");

    stepN(2);
    wait (expQ.size() == 0);
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule